// File: doc/BRIEF.md
# Split-Word Host/Core Mailbox

This block carries 32-bit words in both directions between a debug host and a processor core. The core side moves data only in 16-bit halves. In the inbound direction the host deposits a whole word in one strobe, and the core collects it as two half-word reads. In the outbound direction the core assembles a word from two half-word writes, and the host collects it whole.

Each direction has a flag that both sides can see. The inbound flag says a word is waiting for the core. The outbound flag says a word is waiting for the host. The intended order is lower half first, then upper half. However, the flags respond only to the upper-half access: it completes the transfer on its own, whether or not the lower half was ever touched.

Reset is synchronous and active high. All outputs come from registers.

Top module: `mbox_split_mailbox`

## Requirements
- R1: After reset, `rx_full` and `tx_full` are 0, `host_rd_data` is 0, and a core read of either half of the inbound register returns 0.
- R2: A host write (`host_wr_en`) stores `host_wr_data` in the inbound register and sets `rx_full` on the following cycle.
- R3: A core read (`core_rd_en`) presents the selected half of the inbound register on `core_rd_data` on the following cycle. `core_hi_sel` = 1 selects bits 31:16 and `core_hi_sel` = 0 selects bits 15:0.
- R4: A core read with `core_hi_sel` = 1 clears `rx_full` on the following cycle, even if the lower half was never read.
- R5: A core read with `core_hi_sel` = 0 leaves both `rx_full` and `tx_full` unchanged.
- R6: If a host write and a core upper-half read happen in the same cycle, `rx_full` is 1 afterwards. The read returns the word held before that write.
- R7: A core write (`core_wr_en`) stores `core_wr_data` in the selected half of the outbound register and leaves the other half as it was. The new value shows on `host_rd_data` on the following cycle.
- R8: A core write with `core_hi_sel` = 1 sets `tx_full` on the following cycle, even if the lower half was never written.
- R9: A host read (`host_rd_en`) clears `tx_full` on the following cycle.
- R10: If a core upper-half write and a host read happen in the same cycle, `tx_full` is 1 afterwards.
- R11: A core write with `core_hi_sel` = 0 leaves both `rx_full` and `tx_full` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr_en | input | 1 | Host writes the inbound word |
| host_wr_data | input | 32 | Word written by the host |
| host_rd_en | input | 1 | Host has finished reading the outbound word |
| host_rd_data | output | 32 | Outbound word as seen by the host |
| core_rd_en | input | 1 | Core reads one half of the inbound word |
| core_wr_en | input | 1 | Core writes one half of the outbound word |
| core_hi_sel | input | 1 | Half select for core accesses: 1 = upper, 0 = lower |
| core_wr_data | input | 16 | Half word written by the core |
| core_rd_data | output | 16 | Half word returned to the core |
| rx_full | output | 1 | Inbound word waiting for the core |
| tx_full | output | 1 | Outbound word waiting for the host |

## Verification
Every result of this block is due exactly one clock edge after its strobe:
- the flag changes,
- the `core_rd_data` half,
- the updated `host_rd_data`.

The bench changes its inputs on a falling edge and holds them through one rising edge. It removes them on the next falling edge and samples the outputs at that same moment, half a period after the edge that produced them. The collision cases apply both strobes in one held cycle, so each flag's priority is resolved by a single edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  localparam int unsigned NUM_HALVES = 2;
endpackage

// File: rtl/mbox_flag.sv
// Sticky status bit: set has priority over clear.
module mbox_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/mbox_rx_chan.sv
// Inbound word: written whole by the host, read by halves with a registered read port.
module mbox_rx_chan
  import mbox_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [2*HALF_W-1:0]   wr_data,
  input  logic                  rd_en,
  input  logic                  rd_hi,
  output logic [HALF_W-1:0]     rd_data,
  output logic                  hi_read_o
);
  localparam int unsigned WORD_W = NUM_HALVES * HALF_W;

  logic [HALF_W-1:0] half_q [NUM_HALVES];

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)        half_q[g] <= '0;
      else if (wr_en) half_q[g] <= wr_data[g*HALF_W +: HALF_W];
    end
  end

  // Read-before-write: a same-cycle host write is not seen by this read.
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= half_q[rd_hi];
  end

  assign hi_read_o = rd_en && (half_e'(rd_hi) == HALF_HI);

  logic unused_w;
  assign unused_w = ^WORD_W;
endmodule

// File: rtl/mbox_tx_chan.sv
// Outbound word: written by halves by the core, seen whole by the host.
module mbox_tx_chan
  import mbox_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_hi,
  input  logic [HALF_W-1:0]     wr_data,
  output logic [2*HALF_W-1:0]   word_o,
  output logic                  hi_write_o
);
  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    logic sel;
    assign sel = wr_en && (wr_hi == g[0]);

    always_ff @(posedge clk) begin
      if (rst)      word_o[g*HALF_W +: HALF_W] <= '0;
      else if (sel) word_o[g*HALF_W +: HALF_W] <= wr_data;
    end
  end

  assign hi_write_o = wr_en && (half_e'(wr_hi) == HALF_HI);
endmodule

// File: rtl/mbox_split_mailbox.sv
module mbox_split_mailbox #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [WORD_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [WORD_W-1:0] host_rd_data,
  input  logic              core_rd_en,
  input  logic              core_wr_en,
  input  logic              core_hi_sel,
  input  logic [HALF_W-1:0] core_wr_data,
  output logic [HALF_W-1:0] core_rd_data,
  output logic              rx_full,
  output logic              tx_full
);
  logic rx_hi_read;
  logic tx_hi_write;

  mbox_rx_chan #(.HALF_W(HALF_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (host_wr_en),
    .wr_data   (host_wr_data),
    .rd_en     (core_rd_en),
    .rd_hi     (core_hi_sel),
    .rd_data   (core_rd_data),
    .hi_read_o (rx_hi_read)
  );

  mbox_tx_chan #(.HALF_W(HALF_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (core_wr_en),
    .wr_hi      (core_hi_sel),
    .wr_data    (core_wr_data),
    .word_o     (host_rd_data),
    .hi_write_o (tx_hi_write)
  );

  // Inbound flag: host write sets it, core upper-half read clears it.
  mbox_flag u_rx_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (host_wr_en),
    .clr_i  (rx_hi_read),
    .flag_o (rx_full)
  );

  // Outbound flag: core upper-half write sets it, host read clears it.
  mbox_flag u_tx_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (tx_hi_write),
    .clr_i  (host_rd_en),
    .flag_o (tx_full)
  );
endmodule

// File: rtl/mbox_split_chk.sv
module mbox_split_chk #(
  parameter int unsigned HALF_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                host_wr_en,
  input logic                host_rd_en,
  input logic [2*HALF_W-1:0] host_rd_data,
  input logic                core_rd_en,
  input logic                core_wr_en,
  input logic                core_hi_sel,
  input logic [HALF_W-1:0]   core_wr_data,
  input logic                rx_full,
  input logic                tx_full
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rx_full && !tx_full && host_rd_data == '0));

  p_rx_set_r2: assert property (@(posedge clk) disable iff (rst)
    host_wr_en |=> rx_full);

  p_rx_hi_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (core_rd_en && core_hi_sel && !host_wr_en) |=> !rx_full);

  p_lo_read_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (core_rd_en && !core_hi_sel && !host_wr_en) |=> $stable(rx_full));

  p_collide_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && core_rd_en && core_hi_sel) |=> rx_full);

  p_tx_half_store_r7: assert property (@(posedge clk) disable iff (rst)
    (core_wr_en && !core_hi_sel) |=> host_rd_data[HALF_W-1:0] == $past(core_wr_data));

  p_tx_set_r8: assert property (@(posedge clk) disable iff (rst)
    (core_wr_en && core_hi_sel) |=> tx_full);

  p_tx_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && !(core_wr_en && core_hi_sel)) |=> !tx_full);

  p_collide_tx_r10: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && core_wr_en && core_hi_sel) |=> tx_full);

  p_lo_write_keeps_r11: assert property (@(posedge clk) disable iff (rst)
    (core_wr_en && !core_hi_sel && !host_rd_en) |=> $stable(tx_full));
endmodule

bind mbox_split_mailbox mbox_split_chk #(.HALF_W(HALF_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_wr_en   (host_wr_en),
  .host_rd_en   (host_rd_en),
  .host_rd_data (host_rd_data),
  .core_rd_en   (core_rd_en),
  .core_wr_en   (core_wr_en),
  .core_hi_sel  (core_hi_sel),
  .core_wr_data (core_wr_data),
  .rx_full      (rx_full),
  .tx_full      (tx_full)
);

// File: tb/tb_mbox_split_mailbox.sv
module tb_mbox_split_mailbox;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        host_wr_en;
  logic [31:0] host_wr_data;
  logic        host_rd_en;
  logic [31:0] host_rd_data;
  logic        core_rd_en;
  logic        core_wr_en;
  logic        core_hi_sel;
  logic [15:0] core_wr_data;
  logic [15:0] core_rd_data;
  logic        rx_full;
  logic        tx_full;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_split_mailbox dut (
    .clk          (clk),
    .rst          (rst),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .host_rd_en   (host_rd_en),
    .host_rd_data (host_rd_data),
    .core_rd_en   (core_rd_en),
    .core_wr_en   (core_wr_en),
    .core_hi_sel  (core_hi_sel),
    .core_wr_data (core_wr_data),
    .core_rd_data (core_rd_data),
    .rx_full      (rx_full),
    .tx_full      (tx_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All strobe tasks start at a falling edge and return at the next one,
  // by which time the results of the rising edge in between are visible.
  task automatic idle_inputs();
    host_wr_en = 0; host_rd_en = 0; core_rd_en = 0; core_wr_en = 0;
    core_hi_sel = 0; host_wr_data = '0; core_wr_data = '0;
  endtask

  task automatic host_write(input logic [31:0] d);
    host_wr_en = 1; host_wr_data = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic host_read();
    host_rd_en = 1;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic core_read(input logic hi);
    core_rd_en = 1; core_hi_sel = hi;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic core_write(input logic hi, input logic [15:0] d);
    core_wr_en = 1; core_hi_sel = hi; core_wr_data = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    chk("R1 rx_full", {31'd0, rx_full}, 32'd0);
    chk("R1 tx_full", {31'd0, tx_full}, 32'd0);
    chk("R1 host_rd_data", host_rd_data, 32'd0);
    core_read(1'b0);
    chk("R1 core_rd_data lo", {16'd0, core_rd_data}, 32'd0);
    core_read(1'b1);
    chk("R1 core_rd_data hi", {16'd0, core_rd_data}, 32'd0);
  endtask

  task automatic t_rx_in_order();
    host_write(32'hA5A5_1234);
    chk("R2 rx_full set", {31'd0, rx_full}, 32'd1);
    core_read(1'b0);
    chk("R3 lower half", {16'd0, core_rd_data}, 32'h0000_1234);
    chk("R5 rx_full kept", {31'd0, rx_full}, 32'd1);
    chk("R5 tx_full kept", {31'd0, tx_full}, 32'd0);
    core_read(1'b1);
    chk("R3 upper half", {16'd0, core_rd_data}, 32'h0000_A5A5);
    chk("R4 rx_full cleared", {31'd0, rx_full}, 32'd0);
  endtask

  task automatic t_rx_upper_only();
    host_write(32'hDEAD_BEEF);
    chk("R2 rx_full set again", {31'd0, rx_full}, 32'd1);
    core_read(1'b1);
    chk("R3 upper without lower", {16'd0, core_rd_data}, 32'h0000_DEAD);
    chk("R4 cleared without lower read", {31'd0, rx_full}, 32'd0);
  endtask

  task automatic t_rx_collide();
    host_write(32'h1111_2222);
    host_wr_en = 1; host_wr_data = 32'h3333_4444;
    core_rd_en = 1; core_hi_sel = 1;
    @(negedge clk);
    idle_inputs();
    chk("R6 rx_full stays set", {31'd0, rx_full}, 32'd1);
    chk("R6 read returns prior word", {16'd0, core_rd_data}, 32'h0000_1111);
    core_read(1'b0);
    chk("R6 new word stored", {16'd0, core_rd_data}, 32'h0000_4444);
    core_read(1'b1);
    chk("R4 clear after collide", {31'd0, rx_full}, 32'd0);
  endtask

  task automatic t_tx_in_order();
    core_write(1'b0, 16'hCAFE);
    chk("R11 tx_full not set by lower", {31'd0, tx_full}, 32'd0);
    chk("R7 lower half visible", host_rd_data, 32'h0000_CAFE);
    core_write(1'b1, 16'hBEEF);
    chk("R8 tx_full set", {31'd0, tx_full}, 32'd1);
    chk("R7 full word", host_rd_data, 32'hBEEF_CAFE);
    host_read();
    chk("R9 tx_full cleared", {31'd0, tx_full}, 32'd0);
  endtask

  task automatic t_tx_upper_only();
    core_write(1'b1, 16'h7777);
    chk("R8 set without lower write", {31'd0, tx_full}, 32'd1);
    chk("R7 lower half retained", host_rd_data, 32'h7777_CAFE);
    host_read();
    chk("R9 cleared again", {31'd0, tx_full}, 32'd0);
  endtask

  task automatic t_tx_collide();
    host_write(32'h0BAD_F00D);
    host_rd_en = 1; core_wr_en = 1; core_hi_sel = 1; core_wr_data = 16'h0101;
    @(negedge clk);
    idle_inputs();
    chk("R10 tx_full wins", {31'd0, tx_full}, 32'd1);
    chk("R10 word updated", host_rd_data, 32'h0101_CAFE);
    core_write(1'b0, 16'h5A5A);
    chk("R11 tx_full held by lower write", {31'd0, tx_full}, 32'd1);
    chk("R11 rx_full untouched", {31'd0, rx_full}, 32'd1);
    host_read();
    chk("R9 final clear", {31'd0, tx_full}, 32'd0);
    chk("R7 final word", host_rd_data, 32'h0101_5A5A);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_rx_in_order();
    t_rx_upper_only();
    t_rx_collide();
    t_tx_in_order();
    t_tx_upper_only();
    t_tx_collide();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule